// File: doc/BRIEF.md
# Whole-Block Admission Link for a Wide Stage Bus

This block connects a sending pipeline stage to a buffered receiving stage over a 128-bit word bus. No per-word ready signal exists. The sender moves a block only once the receiver has agreed to take all of it. The receiver keeps a count of free words in its buffer and a flag that marks a block still arriving. The sender waits until that flag is low and the free count covers the whole block. It then reserves the space and sends every word on consecutive clocks. Between the two buffered ends sits one unbuffered stage. That stage places a fixed-size tag in front of each block, so it must take a word on every clock. It keeps one carry register so that bytes pushed past the last input word still go out, in one extra word.

The receiver's buffer storage and the stage datapaths around this link are outside the block. The block tracks only the admission state and the space accounting. The receiver side exposes a pop strobe that returns one word of space each time the downstream logic drains a word. Byte lanes are little-endian: byte k of a word sits at bits 8k+7 down to 8k.

Top module: `blkx_link`

## Requirements
- R1: While reset is held and in the first cycle after it, `rx_free` equals FIFO_WORDS (32 by default), and `rx_busy`, `out_valid` and `src_take` are all low.
- R2: The link grants a block in a cycle where the sender is idle, `src_req` is high, `src_len` is nonzero, `rx_busy` is low and `rx_free` is at least the need. The need is `src_len`, plus one when the final-word byte count plus TAG_BYTES exceeds 16. `src_take` rises in the next cycle.
- R3: In the first cycle of `src_take`, `rx_free` has already fallen by the need and `rx_busy` is high. No output word of the block has arrived by then.
- R4: After a grant, `src_take` stays high for exactly `src_len` consecutive cycles. The sender takes one source word in each of those cycles.
- R5: Each input word appears on the output one cycle after it is taken. The first output word carries `src_tag` in its lowest TAG_BYTES byte lanes, and the payload bytes follow in stream order across the output words.
- R6: `out_sob` marks the first output word of a block and `out_eob` marks its last. `out_bytes` gives the valid byte count of the last word, where 0 means 16. On every other word `out_bytes` is 0.
- R7: When the final input byte count plus TAG_BYTES exceeds 16, one extra output word follows the last input word. That word carries the remaining count minus 16 bytes and sets `out_eob`.
- R8: `rx_busy` falls in the cycle after the output word with `out_eob`. After its last taken word the sender spends one gap cycle and then re-checks admission. With `src_req` held, this leaves two cycles without `src_take` between blocks that do not wrap, and three between blocks that do.
- R9: Each cycle with `rx_pop` high raises `rx_free` by one, unless `rx_free` is already FIFO_WORDS, in which case the pop is ignored. A pop in a grant cycle counts together with the reserved need.
- R10: A request with `src_len` equal to 0 is never granted and leaves `rx_free` unchanged.
- R11: A request whose need exceeds `rx_free` waits without taking words. It is granted in the first cycle in which pops have raised `rx_free` to the need.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 1 | Source has a block ready |
| src_len | input | LEN_W | Block length in input words |
| src_last_bytes | input | 4 | Valid bytes in the final input word, 0 means 16 |
| src_tag | input | 8*TAG_BYTES | Tag placed before the block's payload |
| src_data | input | 128 | Current source word |
| src_take | output | 1 | The current source word is consumed this cycle |
| rx_pop | input | 1 | Receiver drained one word from its buffer |
| rx_free | output | CNT_W | Free receiver words, including reserved space |
| rx_busy | output | 1 | A block is admitted and not yet fully received |
| out_valid | output | 1 | Output word valid |
| out_sob | output | 1 | First word of a block |
| out_eob | output | 1 | Last word of a block |
| out_bytes | output | 4 | Valid bytes of the last word, 0 means 16 |
| out_data | output | 128 | Output word |

## Verification
Two events can land in the same cycle: the space reserved for a newly granted block and a word of space returned by a pop. The bench raises `rx_pop` in the same cycle that it presents an admissible request. The free count one cycle later must equal the old count minus the need plus one. A second test overlaps the pop at full capacity with no grant, and that pop must be dropped. A third holds a request that needs more room than is free while pops arrive. The grant must come exactly in the cycle after the pop that completes the room, and neither earlier nor later.

// File: rtl/blkx_pkg.sv
// Shared constants, bus word type and helpers for the block-admission link.
// Assumes a 16-byte bus with little-endian byte lanes.
package blkx_pkg;

    localparam int unsigned BUS_BYTES = 16;
    localparam int unsigned BUS_W     = 8 * BUS_BYTES;
    localparam int unsigned BCNT_W    = $clog2(BUS_BYTES);

    // One bus word; nbytes is meaningful on the eob word only (0 means full)
    typedef struct packed {
        logic              valid;
        logic              sob;
        logic              eob;
        logic [BCNT_W-1:0] nbytes;
        logic [BUS_W-1:0]  data;
    } bus_word_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_GAP  = 2'd2
    } snd_state_e;

    // Expand the encoded last-word count into 1..BUS_BYTES
    function automatic logic [BCNT_W:0] full_count(input logic [BCNT_W-1:0] c);
        if (c == '0) begin
            return (BCNT_W + 1)'(BUS_BYTES);
        end
        return {1'b0, c};
    endfunction

endpackage

// File: rtl/blkx_sender.sv
// Sender side of the link. Waits until the receiver is idle and has room
// for the whole block (plus one word if the tag pushes bytes into an
// extra output word), then streams src_len words with no break, then
// spends one gap cycle before the next admission check.
// Assumes the source presents a new word every cycle src_take is high.
module blkx_sender
    import blkx_pkg::*;
#(
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned TAG_BYTES = 4,
    parameter int unsigned TAG_W     = 8 * TAG_BYTES,
    parameter int unsigned NEED_W    = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [LEN_W-1:0]  len,
    input  logic [BCNT_W-1:0] last_bytes,
    input  logic [TAG_W-1:0]  tag,
    input  logic [BUS_W-1:0]  data,
    input  logic              rx_busy,
    input  logic [CNT_W-1:0]  rx_free,
    output logic              take,
    output logic              grant,
    output logic [NEED_W-1:0] need,
    output logic [TAG_W-1:0]  tag_q,
    output bus_word_t         bus_o
);

    localparam int unsigned CMP_W = (CNT_W > NEED_W) ? CNT_W : NEED_W;
    localparam int unsigned TOT_W = BCNT_W + 2;

    snd_state_e        state;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  len_q;
    logic [BCNT_W-1:0] nb_q;
    logic              wraps;
    logic              room;
    logic              at_last;

    // Output length of the requested block and the admission decision
    always_comb begin
        wraps = ({1'b0, full_count(last_bytes)} + TOT_W'(TAG_BYTES)) > TOT_W'(BUS_BYTES);
        need  = {1'b0, len} + NEED_W'(wraps);
        room  = CMP_W'(rx_free) >= CMP_W'(need);
        grant = (state == S_IDLE) && req && (len != '0) && !rx_busy && room;
    end

    assign at_last = (idx == (len_q - LEN_W'(1)));
    assign take    = (state == S_SEND);

    // Sequencing: idle -> send len words -> one gap cycle -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            len_q <= '0;
            nb_q  <= '0;
            tag_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (grant) begin
                        state <= S_SEND;
                        idx   <= '0;
                        len_q <= len;
                        nb_q  <= last_bytes;
                        tag_q <= tag;
                    end
                end
                S_SEND: begin
                    idx <= idx + LEN_W'(1);
                    if (at_last) begin
                        state <= S_GAP;
                    end
                end
                S_GAP:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the internal bus word while sending
    always_comb begin
        bus_o = '0;
        if (state == S_SEND) begin
            bus_o.valid  = 1'b1;
            bus_o.sob    = (idx == '0);
            bus_o.eob    = at_last;
            bus_o.nbytes = at_last ? nb_q : '0;
            bus_o.data   = data;
        end
    end

endmodule

// File: rtl/blkx_wrap_stage.sv
// Unbuffered stage: places TAG_BYTES tag bytes before each block's payload.
// It cannot stall, so it takes one word per cycle, and it keeps a carry
// register for the top TAG_BYTES of the previous word. When the final word
// overflows, the carry is emitted as one extra word in the next cycle.
// Assumes at least one idle input cycle after every eob word.
module blkx_wrap_stage
    import blkx_pkg::*;
#(
    parameter int unsigned TAG_BYTES = 4,
    parameter int unsigned TAG_W     = 8 * TAG_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_word_t        in_w,
    input  logic [TAG_W-1:0] tag,
    output bus_word_t        out_w
);

    localparam int unsigned KEEP_W = BUS_W - TAG_W;
    localparam int unsigned TOT_W  = BCNT_W + 2;

    bus_word_t         out_q;
    logic [TAG_W-1:0]  carry;
    logic              pend;
    logic [BCNT_W-1:0] pend_n;
    logic [TOT_W-1:0]  tot;
    logic              over;

    // Byte total of the final word after the shift
    always_comb begin
        tot  = {1'b0, full_count(in_w.nbytes)} + TOT_W'(TAG_BYTES);
        over = tot > TOT_W'(BUS_BYTES);
    end

    // Shift by TAG_BYTES lanes, carrying the top lanes into the next word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            carry  <= '0;
            pend   <= 1'b0;
            pend_n <= '0;
        end else if (in_w.valid) begin
            out_q.valid <= 1'b1;
            out_q.sob   <= in_w.sob;
            out_q.data  <= {in_w.data[KEEP_W-1:0], (in_w.sob ? tag : carry)};
            carry       <= in_w.data[BUS_W-1 -: TAG_W];
            if (in_w.eob && over) begin
                out_q.eob    <= 1'b0;
                out_q.nbytes <= '0;
                pend         <= 1'b1;
                pend_n       <= BCNT_W'(tot - TOT_W'(BUS_BYTES));
            end else if (in_w.eob) begin
                out_q.eob    <= 1'b1;
                out_q.nbytes <= tot[BCNT_W-1:0];
            end else begin
                out_q.eob    <= 1'b0;
                out_q.nbytes <= '0;
            end
        end else if (pend) begin
            out_q.valid  <= 1'b1;
            out_q.sob    <= 1'b0;
            out_q.eob    <= 1'b1;
            out_q.nbytes <= pend_n;
            out_q.data   <= {{KEEP_W{1'b0}}, carry};
            pend         <= 1'b0;
        end else begin
            out_q <= '0;
        end
    end

    assign out_w = out_q;

endmodule

// File: rtl/blkx_rx_credit.sv
// Receiver-side accounting: free word count and the in-progress flag.
// Space is reserved on the grant cycle and returned by pops; a pop when
// the count is already at capacity is dropped.
// Assumes grant is only raised when need <= free and busy is low.
module blkx_rx_credit #(
    parameter int unsigned FIFO_WORDS = 32,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned NEED_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [NEED_W-1:0] need,
    input  logic              pop,
    input  logic              blk_done,
    output logic [CNT_W-1:0]  free,
    output logic              busy
);

    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(FIFO_WORDS);

    logic             pop_ok;
    logic [CNT_W-1:0] take_n;

    assign pop_ok = pop && (free != CAP_V);
    assign take_n = grant ? CNT_W'(need) : '0;

    // Free count: subtract the reservation, add back drained words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free <= CAP_V;
        end else begin
            free <= free - take_n + CNT_W'(pop_ok);
        end
    end

    // In-progress flag: set on grant, cleared after the final word lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (grant) begin
            busy <= 1'b1;
        end else if (blk_done) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/blkx_link.sv
// Top of the block-admission link: sender, tag-inserting unbuffered stage
// and receiver accounting. Words leave on out_* one cycle after they are
// taken from the source.
// Assumes 1 <= TAG_BYTES <= 15 and that no block needs more than FIFO_WORDS.
module blkx_link
    import blkx_pkg::*;
#(
    parameter  int unsigned LEN_W      = 8,
    parameter  int unsigned FIFO_WORDS = 32,
    parameter  int unsigned TAG_BYTES  = 4,
    localparam int unsigned CNT_W      = $clog2(FIFO_WORDS + 1),
    localparam int unsigned TAG_W      = 8 * TAG_BYTES,
    localparam int unsigned NEED_W     = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_req,
    input  logic [LEN_W-1:0]  src_len,
    input  logic [BCNT_W-1:0] src_last_bytes,
    input  logic [TAG_W-1:0]  src_tag,
    input  logic [BUS_W-1:0]  src_data,
    output logic              src_take,
    input  logic              rx_pop,
    output logic [CNT_W-1:0]  rx_free,
    output logic              rx_busy,
    output logic              out_valid,
    output logic              out_sob,
    output logic              out_eob,
    output logic [BCNT_W-1:0] out_bytes,
    output logic [BUS_W-1:0]  out_data
);

    bus_word_t         bus_a;
    bus_word_t         bus_b;
    logic              grant;
    logic [NEED_W-1:0] need;
    logic [TAG_W-1:0]  tag_q;

    blkx_sender #(
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .TAG_BYTES (TAG_BYTES),
        .TAG_W     (TAG_W),
        .NEED_W    (NEED_W)
    ) u_snd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (src_req),
        .len        (src_len),
        .last_bytes (src_last_bytes),
        .tag        (src_tag),
        .data       (src_data),
        .rx_busy    (rx_busy),
        .rx_free    (rx_free),
        .take       (src_take),
        .grant      (grant),
        .need       (need),
        .tag_q      (tag_q),
        .bus_o      (bus_a)
    );

    blkx_wrap_stage #(
        .TAG_BYTES (TAG_BYTES),
        .TAG_W     (TAG_W)
    ) u_wrap (
        .clk   (clk),
        .rst_n (rst_n),
        .in_w  (bus_a),
        .tag   (tag_q),
        .out_w (bus_b)
    );

    blkx_rx_credit #(
        .FIFO_WORDS (FIFO_WORDS),
        .CNT_W      (CNT_W),
        .NEED_W     (NEED_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .need     (need),
        .pop      (rx_pop),
        .blk_done (bus_b.valid && bus_b.eob),
        .free     (rx_free),
        .busy     (rx_busy)
    );

    assign out_valid = bus_b.valid;
    assign out_sob   = bus_b.sob;
    assign out_eob   = bus_b.eob;
    assign out_bytes = bus_b.nbytes;
    assign out_data  = bus_b.data;

endmodule

// File: rtl/blkx_link_chk.sv
// Protocol checker for blkx_link, attached by bind below.
module blkx_link_chk
    import blkx_pkg::*;
#(
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned FIFO_WORDS = 32,
    parameter int unsigned TAG_BYTES  = 4,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned NEED_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEN_W-1:0]  src_len,
    input logic              grant,
    input logic [NEED_W-1:0] need,
    input logic              rx_pop,
    input logic [CNT_W-1:0]  rx_free,
    input logic              rx_busy,
    input bus_word_t         bus_a,
    input logic              out_valid,
    input logic              out_eob,
    input logic [BCNT_W-1:0] out_bytes
);

    logic a_wraps;
    assign a_wraps = (int'(full_count(bus_a.nbytes)) + int'(TAG_BYTES)) > int'(BUS_BYTES);

    // R2: a grant only with an idle receiver that has room
    a_r2_admit: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (!rx_busy && int'(rx_free) >= int'(need)));

    // R10: zero-length requests are never granted
    a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (src_len != '0));

    // R3: reservation applied on the grant edge
    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !rx_pop) |=> (rx_busy && int'(rx_free) == int'($past(rx_free)) - int'($past(need))));

    // R4: no break inside a block
    a_r4_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_a.valid && !bus_a.eob) |=> (bus_a.valid && !bus_a.sob));

    // R8: an idle cycle follows every final input word
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_a.valid && bus_a.eob) |=> !bus_a.valid);

    // R5: one-cycle latency through the unbuffered stage
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bus_a.valid |=> out_valid);

    // R6: byte count only on the final word
    a_r6_nbytes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eob) |-> (out_bytes == '0));

    // R7: overflowing final word produces exactly one extra word
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_a.valid && bus_a.eob && a_wraps) |=> (out_valid && !out_eob) ##1 (out_valid && out_eob));

    // R8: busy drops after the final output word
    a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eob) |=> !rx_busy);

    // R9: free count never exceeds capacity
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r9_bound: assert (int'(rx_free) <= int'(FIFO_WORDS));
        end
    end

endmodule

bind blkx_link blkx_link_chk #(
    .LEN_W      (LEN_W),
    .FIFO_WORDS (FIFO_WORDS),
    .TAG_BYTES  (TAG_BYTES),
    .CNT_W      (CNT_W),
    .NEED_W     (NEED_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_len   (src_len),
    .grant     (grant),
    .need      (need),
    .rx_pop    (rx_pop),
    .rx_free   (rx_free),
    .rx_busy   (rx_busy),
    .bus_a     (bus_a),
    .out_valid (out_valid),
    .out_eob   (out_eob),
    .out_bytes (out_bytes)
);

// File: tb/sim_blkx_link.sv
module sim_blkx_link;

    localparam int CAP = 32;
    localparam int TB  = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         src_req;
    logic [7:0]   src_len;
    logic [3:0]   src_last_bytes;
    logic [31:0]  src_tag;
    logic [127:0] src_data;
    logic         src_take;
    logic         rx_pop;
    logic [5:0]   rx_free;
    logic         rx_busy;
    logic         out_valid, out_sob, out_eob;
    logic [3:0]   out_bytes;
    logic [127:0] out_data;

    int checks = 0;
    int fails  = 0;
    int src_idx = 0;
    int exp_free = CAP;
    int mon_n = 0;
    logic [127:0] mon_d [0:63];
    logic         mon_s [0:63];
    logic         mon_e [0:63];
    logic [3:0]   mon_b [0:63];

    always #5 clk = ~clk;

    blkx_link u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_len(src_len),
        .src_last_bytes(src_last_bytes), .src_tag(src_tag), .src_data(src_data),
        .src_take(src_take), .rx_pop(rx_pop), .rx_free(rx_free), .rx_busy(rx_busy),
        .out_valid(out_valid), .out_sob(out_sob), .out_eob(out_eob),
        .out_bytes(out_bytes), .out_data(out_data)
    );

    function automatic logic [127:0] pat(input int i);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[8*b +: 8] = 8'(i * 29 + b * 7 + 3);
        return r;
    endfunction

    assign src_data = pat(src_idx);

    // Source model: advance one word per consumed cycle
    always @(posedge clk) if (src_take) src_idx <= src_idx + 1;

    // Output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (out_valid && mon_n < 64) begin
            mon_d[mon_n] = out_data;
            mon_s[mon_n] = out_sob;
            mon_e[mon_n] = out_eob;
            mon_b[mon_n] = out_bytes;
            mon_n = mon_n + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int need_of(input int len, input int nb);
        int nbe = (nb == 0) ? 16 : nb;
        return len + ((nbe + TB > 16) ? 1 : 0);
    endfunction

    task automatic check_block(input int base, input int len, input int nb,
                               input logic [31:0] tag, input string rq);
        int nbe = (nb == 0) ? 16 : nb;
        int total = TB + (len - 1) * 16 + nbe;
        int nw = (total + 15) / 16;
        int errs = 0;
        chk(mon_n == nw, {rq, " R7 word count"}, mon_n, nw);
        if (mon_n == nw) begin
            for (int w = 0; w < nw; w++) begin
                int vb = (w == nw - 1) ? total - 16 * w : 16;
                if (mon_s[w] != (w == 0)) errs++;
                if (mon_e[w] != (w == nw - 1)) errs++;
                if (mon_b[w] != ((w == nw - 1) ? 4'(total % 16) : 4'd0)) errs++;
                for (int b = 0; b < vb; b++) begin
                    int p = 16 * w + b;
                    logic [7:0] e;
                    if (p < TB) e = tag[8*p +: 8];
                    else begin
                        logic [127:0] pw = pat(base + (p - TB) / 16);
                        e = pw[8*((p - TB) % 16) +: 8];
                    end
                    if (mon_d[w][8*b +: 8] != e) errs++;
                end
            end
        end
        chk(errs == 0, {rq, " R5 R6 data and markers"}, errs, 0);
    endtask

    // One admitted block, checked end to end
    task automatic t_block(input int len, input int nb, input logic [31:0] tag, input string rq);
        int base = src_idx;
        int need = need_of(len, nb);
        int n = 0;
        mon_n = 0;
        src_len = 8'(len); src_last_bytes = 4'(nb); src_tag = tag; src_req = 1'b1;
        @(negedge clk);
        chk(src_take == 1'b1, {rq, " R2 start"}, src_take, 1);
        chk(int'(rx_free) == exp_free - need, {rq, " R3 free"}, rx_free, exp_free - need);
        chk(rx_busy == 1'b1, {rq, " R3 busy"}, rx_busy, 1);
        src_req = 1'b0;
        exp_free -= need;
        while (src_take && n < 300) begin n++; @(negedge clk); end
        chk(n == len, {rq, " R4 take run"}, n, len);
        repeat (4) @(negedge clk);
        chk(rx_busy == 1'b0, {rq, " R8 busy clear"}, rx_busy, 0);
        check_block(base, len, nb, tag, rq);
    endtask

    task automatic pops(input int n);
        rx_pop = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (exp_free < CAP) exp_free++;
        end
        rx_pop = 1'b0;
    endtask

    task automatic t_zero_len;
        src_len = 8'd0; src_last_bytes = 4'd5; src_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(src_take == 1'b0, "R10 zero length take", src_take, 0);
        end
        chk(int'(rx_free) == exp_free, "R10 free unchanged", rx_free, exp_free);
        src_req = 1'b0;
    endtask

    task automatic t_no_room;
        int base = src_idx;
        src_len = 8'd30; src_last_bytes = 4'd5; src_tag = 32'h1122_3344; src_req = 1'b1;
        mon_n = 0;
        repeat (4) begin
            @(negedge clk);
            chk(src_take == 1'b0, "R11 waits for room", src_take, 0);
        end
        rx_pop = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            exp_free++;
            if (i < 7) chk(src_take == 1'b0, "R11 still short", src_take, 0);
        end
        rx_pop = 1'b0;
        chk(src_take == 1'b0 && int'(rx_free) == 30, "R11 room reached", rx_free, 30);
        @(negedge clk);
        chk(src_take == 1'b1, "R11 granted next cycle", src_take, 1);
        chk(int'(rx_free) == 0, "R11 reserved", rx_free, 0);
        src_req = 1'b0;
        exp_free = 0;
        repeat (36) @(negedge clk);
        check_block(base, 30, 5, 32'h1122_3344, "R11 long block");
    endtask

    task automatic t_pop_cap;
        pops(CAP);
        chk(int'(rx_free) == CAP, "R9 refill", rx_free, CAP);
        pops(1);
        chk(int'(rx_free) == CAP, "R9 pop at capacity ignored", rx_free, CAP);
    endtask

    task automatic t_b2b(input int nb, input logic [9:0] exp_bits, input string rq);
        logic [9:0] got = '0;
        bit dropped = 1'b0;
        int n = 0;
        src_len = 8'd2; src_last_bytes = 4'(nb); src_tag = 32'h0BAD_F00D; src_req = 1'b1;
        while (!src_take && n < 20) begin @(negedge clk); n++; end
        for (int i = 0; i < 10; i++) begin
            got[i] = src_take;
            if (i >= 2 && src_take && !dropped) begin src_req = 1'b0; dropped = 1'b1; end
            @(negedge clk);
        end
        src_req = 1'b0;
        chk(got == exp_bits, {rq, " R8 take pattern"}, got, exp_bits);
        exp_free -= 2 * need_of(2, nb);
        repeat (4) @(negedge clk);
        chk(int'(rx_free) == exp_free, {rq, " R3 free after pair"}, rx_free, exp_free);
    endtask

    task automatic t_pop_with_grant;
        int base = src_idx;
        mon_n = 0;
        src_len = 8'd3; src_last_bytes = 4'd5; src_tag = 32'h5566_7788; src_req = 1'b1;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0; src_req = 1'b0;
        chk(src_take == 1'b1, "R9 grant with pop", src_take, 1);
        chk(int'(rx_free) == exp_free - 3 + 1, "R9 pop and commit same cycle", rx_free, exp_free - 2);
        exp_free -= 2;
        repeat (8) @(negedge clk);
        check_block(base, 3, 5, 32'h5566_7788, "R9 block");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req = 1'b0; src_len = '0; src_last_bytes = '0;
        src_tag = '0; rx_pop = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(rx_free) == CAP && !rx_busy && !out_valid && !src_take,
            "R1 reset state", rx_free, CAP);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(rx_free) == CAP && !rx_busy && !out_valid && !src_take,
            "R1 after reset", rx_free, CAP);

        t_block(3, 5, 32'hA1B2_C3D4, "basic");        // 32 -> 29
        t_block(2, 14, 32'hDEAD_BEEF, "R7 wrap");     // -> 26
        t_block(1, 0, 32'h0102_0304, "R7 full last"); // -> 24
        t_block(2, 12, 32'hCAFE_0001, "R6 exact fit");// -> 22
        t_zero_len();
        t_no_room();
        t_pop_cap();
        t_b2b(5, 10'b00_0011_0011, "no wrap");
        t_b2b(14, 10'b00_0110_0011, "wrap");
        t_pop_with_grant();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule